// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the control engine of one DMA channel. It walks a chain of descriptors held in a dedicated memory, one 32-bit word at a time, through a simple read port. For every data descriptor whose cycle bit matches the channel's own consumer cycle state, it issues exactly one copy command. The command carries a 64-bit source, a 64-bit destination and a 32-bit byte length. The block then waits for the data mover to report completion before it moves on. A link element ends the current list. The walker jumps to the next-list pointer held in the link element and flips its expected cycle state.

Software starts or resumes the walker with a doorbell. The doorbell can also load a fresh list address, which resets the cycle state to 1. The walker parks itself when it meets a stale descriptor, and stays parked until the next doorbell. When a descriptor has interrupt-enable bits set and finishes, the walker raises a one-cycle done pulse. A zero length or a failed copy raises a one-cycle abort pulse and stops the channel. Every pulse is also kept in a sticky status bit, which is cleared by write-one-to-clear inputs. Several instances, each set to the write or read direction by a parameter, make up a multi-engine channel group.

The memory read request and the copy command are valid/ready streams. The request address and the command fields stay stable while valid is high and ready is low, and a transfer happens on a clock edge where both are high. The read response and the completion are single-cycle strobes that are always accepted. Only one read and one command are ever outstanding.

Top module: `ll_dma_walker`

## Requirements
- R1: After reset the block is idle (busy low), with cmd_valid, mem_req_valid, both sticky bits and all interrupt pulses low, and cons_cycle high.
- R2: A descriptor takes six 32-bit words at byte offsets 0 to 20 from its address: control, length, source low, source high, destination low, destination high. A matching data descriptor produces one command with cmd_len = length, cmd_src = {source high, source low} and cmd_dst = {destination high, destination low}. After a good completion, the next descriptor is read at address + 24.
- R3: The walker compares control bit 0 (cycle) with cons_cycle. On a mismatch it issues no command, reads no body word and drops busy.
- R4: Control bit 1 marks a link element. Its words 2 and 3 form the next-list pointer, whose low ADDR_W bits become the next descriptor address, and cons_cycle inverts.
- R5: A doorbell with db_load high sets the descriptor address to db_addr and cons_cycle to 1. A doorbell with db_load low resumes at the held address with the held cycle state. A doorbell while busy has no effect.
- R6: A data descriptor with length zero issues no command. It pulses irq_abort, stops the walker and puts that descriptor's address on err_addr.
- R7: A completion with cpl_err high pulses irq_abort, stops the walker and puts the failing descriptor's address on err_addr. No further command is issued.
- R8: After a good completion, control bit 3 set gives a one-cycle irq_done_loc pulse and control bit 4 set gives a one-cycle irq_done_rem pulse, in the cycle after the completion strobe.
- R9: st_done is set by either done pulse and st_abort by an abort pulse. Each stays set until its clear input is high with no new event in that cycle.
- R10: Under back-pressure, mem_req_addr and the command fields stay stable until accepted, and the command sequence is unchanged by stalls.
- R11: cmd_dir is constant and equals the READ_DIR parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_valid | input | 1 | Doorbell strobe |
| db_load | input | 1 | Doorbell loads db_addr and resets cycle state |
| db_addr | input | ADDR_W | New list address for a loading doorbell |
| mem_req_valid | output | 1 | Descriptor word read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | ADDR_W | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Read data word |
| cmd_valid | output | 1 | Copy command valid |
| cmd_ready | input | 1 | Data mover accepts the command |
| cmd_src | output | SYS_AW | Copy source byte address |
| cmd_dst | output | SYS_AW | Copy destination byte address |
| cmd_len | output | 32 | Copy length in bytes |
| cmd_dir | output | 1 | Engine direction, from READ_DIR |
| cpl_valid | input | 1 | Completion strobe for the outstanding command |
| cpl_err | input | 1 | Completion reports failure |
| irq_done_loc | output | 1 | Local done interrupt pulse |
| irq_done_rem | output | 1 | Remote done interrupt pulse |
| irq_abort | output | 1 | Abort interrupt pulse |
| st_done | output | 1 | Sticky done status |
| st_abort | output | 1 | Sticky abort status |
| clr_done | input | 1 | Write-one-to-clear for st_done |
| clr_abort | input | 1 | Write-one-to-clear for st_abort |
| err_addr | output | ADDR_W | Address of the descriptor that aborted |
| busy | output | 1 | Walker active |
| cons_cycle | output | 1 | Current consumer cycle state |

## Verification
The assertions take the following for granted about the inputs. Doorbell addresses and link pointers are word aligned. The memory returns exactly one response strobe for each accepted read. The data mover gives exactly one completion strobe for each accepted command, never in the same cycle as the handshake. The bench memory and data-mover models keep to this: each model holds one pending item, answers it after a random delay and only then takes the next. Every descriptor the bench builds sits at a multiple of 24 bytes from an aligned base. Ready on both streams is randomised at several acceptance rates, so stalls fall on every word and command.

// File: rtl/llw_pkg.sv
`timescale 1ns/1ps
package llw_pkg;
  localparam int WORD_W     = 32;
  localparam int DESC_WORDS = 6;
  localparam int IDX_W      = $clog2(DESC_WORDS);
  localparam int DESC_BYTES = DESC_WORDS * (WORD_W / 8);

  // word positions inside a descriptor
  localparam int W_CTRL   = 0;
  localparam int W_LEN    = 1;
  localparam int W_SRC_LO = 2;
  localparam int W_SRC_HI = 3;
  localparam int W_DST_LO = 4;
  localparam int W_DST_HI = 5;

  // control word bit positions
  localparam int CB_CYCLE = 0;
  localparam int CB_LINK  = 1;
  localparam int CB_LIE   = 3;
  localparam int CB_RIE   = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GO_CTRL, ST_CTRL, ST_GO_BODY,
    ST_BODY, ST_LINK, ST_CMD, ST_CPL
  } walk_st_t;
endpackage

// File: rtl/llw_word_fetch.sv
`timescale 1ns/1ps
module llw_word_fetch import llw_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  first,
  input  logic [IDX_W-1:0]  last,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              w_valid,
  output logic [IDX_W-1:0]  w_idx,
  output logic [WORD_W-1:0] w_data,
  output logic              done
);
  logic              active, waiting;
  logic [IDX_W-1:0]  idx, last_q;
  logic [ADDR_W-1:0] base_q;

  assign mem_req_valid = active && !waiting;
  assign mem_req_addr  = base_q + ADDR_W'({idx, 2'b00});
  assign w_valid       = active && waiting && mem_rsp_valid;
  assign w_idx         = idx;
  assign w_data        = mem_rsp_data;
  assign done          = w_valid && (idx == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      waiting <= 1'b0;
      idx     <= '0;
      last_q  <= '0;
      base_q  <= '0;
    end else if (go) begin
      active  <= 1'b1;
      waiting <= 1'b0;
      idx     <= first;
      last_q  <= last;
      base_q  <= base;
    end else if (active) begin
      if (!waiting && mem_req_ready) begin
        waiting <= 1'b1;
      end else if (waiting && mem_rsp_valid) begin
        waiting <= 1'b0;
        if (idx == last_q) active <= 1'b0;
        else               idx    <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/llw_irq_status.sv
`timescale 1ns/1ps
module llw_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic done_loc_ev,
  input  logic done_rem_ev,
  input  logic abort_ev,
  input  logic clr_done,
  input  logic clr_abort,
  output logic irq_done_loc,
  output logic irq_done_rem,
  output logic irq_abort,
  output logic st_done,
  output logic st_abort
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_done_loc <= 1'b0;
      irq_done_rem <= 1'b0;
      irq_abort    <= 1'b0;
      st_done      <= 1'b0;
      st_abort     <= 1'b0;
    end else begin
      irq_done_loc <= done_loc_ev;
      irq_done_rem <= done_rem_ev;
      irq_abort    <= abort_ev;
      // a new event wins over a clear in the same cycle
      st_done      <= done_loc_ev | done_rem_ev | (st_done & ~clr_done);
      st_abort     <= abort_ev | (st_abort & ~clr_abort);
    end
  end
endmodule

// File: rtl/ll_dma_walker.sv
`timescale 1ns/1ps
module ll_dma_walker import llw_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int SYS_AW   = 64,
  parameter bit READ_DIR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid,
  input  logic              db_load,
  input  logic [ADDR_W-1:0] db_addr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [SYS_AW-1:0] cmd_src,
  output logic [SYS_AW-1:0] cmd_dst,
  output logic [31:0]       cmd_len,
  output logic              cmd_dir,
  input  logic              cpl_valid,
  input  logic              cpl_err,
  output logic              irq_done_loc,
  output logic              irq_done_rem,
  output logic              irq_abort,
  output logic              st_done,
  output logic              st_abort,
  input  logic              clr_done,
  input  logic              clr_abort,
  output logic [ADDR_W-1:0] err_addr,
  output logic              busy,
  output logic              cons_cycle
);
  localparam int PTR_W = 2 * WORD_W;

  walk_st_t          st;
  logic [ADDR_W-1:0] ptr;
  logic              cyc;
  logic [WORD_W-1:0] len_q;
  logic [PTR_W-1:0]  src_q, dst_q;
  logic              lnk_q, lie_q, rie_q;

  logic              f_go, f_wvalid, f_done;
  logic [IDX_W-1:0]  f_first, f_last, f_widx;
  logic [WORD_W-1:0] f_wdata;
  logic              abort_ev, done_loc_ev, done_rem_ev, cpl_ok;

  assign f_go    = (st == ST_GO_CTRL) || (st == ST_GO_BODY);
  assign f_first = (st == ST_GO_BODY) ? (lnk_q ? IDX_W'(W_SRC_LO) : IDX_W'(W_LEN))
                                      : IDX_W'(W_CTRL);
  assign f_last  = (st == ST_GO_BODY) ? (lnk_q ? IDX_W'(W_SRC_HI) : IDX_W'(W_DST_HI))
                                      : IDX_W'(W_CTRL);

  llw_word_fetch #(.ADDR_W(ADDR_W)) u_fetch (
    .clk(clk), .rst_n(rst_n), .go(f_go), .base(ptr),
    .first(f_first), .last(f_last),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .w_valid(f_wvalid), .w_idx(f_widx),
    .w_data(f_wdata), .done(f_done)
  );

  assign cpl_ok      = (st == ST_CPL) && cpl_valid && !cpl_err;
  assign done_loc_ev = cpl_ok && lie_q;
  assign done_rem_ev = cpl_ok && rie_q;
  assign abort_ev    = ((st == ST_BODY) && f_done && !lnk_q && (len_q == '0)) ||
                       ((st == ST_CPL) && cpl_valid && cpl_err);

  llw_irq_status u_status (
    .clk(clk), .rst_n(rst_n),
    .done_loc_ev(done_loc_ev), .done_rem_ev(done_rem_ev), .abort_ev(abort_ev),
    .clr_done(clr_done), .clr_abort(clr_abort),
    .irq_done_loc(irq_done_loc), .irq_done_rem(irq_done_rem), .irq_abort(irq_abort),
    .st_done(st_done), .st_abort(st_abort)
  );

  // descriptor word capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      lnk_q <= 1'b0;
      lie_q <= 1'b0;
      rie_q <= 1'b0;
    end else if (f_wvalid) begin
      case (f_widx)
        IDX_W'(W_CTRL): begin
          lnk_q <= f_wdata[CB_LINK];
          lie_q <= f_wdata[CB_LIE];
          rie_q <= f_wdata[CB_RIE];
        end
        IDX_W'(W_LEN):    len_q               <= f_wdata;
        IDX_W'(W_SRC_LO): src_q[WORD_W-1:0]   <= f_wdata;
        IDX_W'(W_SRC_HI): src_q[PTR_W-1:WORD_W] <= f_wdata;
        IDX_W'(W_DST_LO): dst_q[WORD_W-1:0]   <= f_wdata;
        IDX_W'(W_DST_HI): dst_q[PTR_W-1:WORD_W] <= f_wdata;
        default: ;
      endcase
    end
  end

  // walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      cyc      <= 1'b1;
      err_addr <= '0;
    end else begin
      if (abort_ev) err_addr <= ptr;
      case (st)
        ST_IDLE: if (db_valid) begin
          if (db_load) begin
            ptr <= db_addr;
            cyc <= 1'b1;
          end
          st <= ST_GO_CTRL;
        end
        ST_GO_CTRL: st <= ST_CTRL;
        ST_CTRL: if (f_done) begin
          st <= (f_wdata[CB_CYCLE] == cyc) ? ST_GO_BODY : ST_IDLE;
        end
        ST_GO_BODY: st <= ST_BODY;
        ST_BODY: if (f_done) begin
          if (lnk_q)              st <= ST_LINK;
          else if (len_q == '0)   st <= ST_IDLE;
          else                    st <= ST_CMD;
        end
        ST_LINK: begin
          ptr <= src_q[ADDR_W-1:0];
          cyc <= ~cyc;
          st  <= ST_GO_CTRL;
        end
        ST_CMD: if (cmd_ready) st <= ST_CPL;
        ST_CPL: if (cpl_valid) begin
          if (cpl_err) st <= ST_IDLE;
          else begin
            ptr <= ptr + ADDR_W'(DESC_BYTES);
            st  <= ST_GO_CTRL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid  = (st == ST_CMD);
  assign cmd_src    = src_q[SYS_AW-1:0];
  assign cmd_dst    = dst_q[SYS_AW-1:0];
  assign cmd_len    = len_q;
  assign cmd_dir    = READ_DIR;
  assign busy       = (st != ST_IDLE);
  assign cons_cycle = cyc;
endmodule

// File: rtl/llw_checker.sv
`timescale 1ns/1ps
module llw_checker #(
  parameter int ADDR_W = 32,
  parameter int SYS_AW = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [SYS_AW-1:0] cmd_src,
  input logic [SYS_AW-1:0] cmd_dst,
  input logic [31:0]       cmd_len,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              irq_done_loc,
  input logic              irq_done_rem,
  input logic              irq_abort,
  input logic              st_done,
  input logic              st_abort,
  input logic              clr_done,
  input logic              clr_abort
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_src) && $stable(cmd_dst) && $stable(cmd_len)); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10
  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len != '0); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !mem_req_valid); // R3
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |-> !busy); // R7
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |=> !irq_abort); // R7
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |-> !irq_done_loc && !irq_done_rem); // R8
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |-> st_abort); // R9
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done_loc || irq_done_rem |-> st_done); // R9
  AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_abort && !clr_abort |=> st_abort); // R9
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_done && !clr_done |=> st_done); // R9
endmodule

bind ll_dma_walker llw_checker #(.ADDR_W(ADDR_W), .SYS_AW(SYS_AW)) i_llw_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_len(cmd_len),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .irq_done_loc(irq_done_loc), .irq_done_rem(irq_done_rem), .irq_abort(irq_abort),
  .st_done(st_done), .st_abort(st_abort), .clr_done(clr_done), .clr_abort(clr_abort)
);

// File: tb/test_ll_dma_walker.sv
`timescale 1ns/1ps
module test_ll_dma_walker;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          db_valid = 1'b0, db_load = 1'b0;
  logic [AW-1:0] db_addr = '0;
  logic          mem_req_valid, mem_req_ready = 1'b0;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [31:0]   mem_rsp_data = '0;
  logic          cmd_valid, cmd_ready = 1'b0, cmd_dir;
  logic [63:0]   cmd_src, cmd_dst;
  logic [31:0]   cmd_len;
  logic          cpl_valid = 1'b0, cpl_err = 1'b0;
  logic          irq_done_loc, irq_done_rem, irq_abort, st_done, st_abort;
  logic          clr_done = 1'b0, clr_abort = 1'b0;
  logic [AW-1:0] err_addr;
  logic          busy, cons_cycle;

  ll_dma_walker #(.ADDR_W(AW), .SYS_AW(64), .READ_DIR(1'b1)) i_ll_dma_walker (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_load(db_load), .db_addr(db_addr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_src(cmd_src), .cmd_dst(cmd_dst),
    .cmd_len(cmd_len), .cmd_dir(cmd_dir), .cpl_valid(cpl_valid), .cpl_err(cpl_err),
    .irq_done_loc(irq_done_loc), .irq_done_rem(irq_done_rem), .irq_abort(irq_abort),
    .st_done(st_done), .st_abort(st_abort), .clr_done(clr_done), .clr_abort(clr_abort),
    .err_addr(err_addr), .busy(busy), .cons_cycle(cons_cycle)
  );

  logic [31:0] mem [1024];
  logic [63:0] e_src [64], e_dst [64], g_src [64], g_dst [64];
  logic [31:0] e_len [64], g_len [64];
  int n_exp, n_got, cnt_loc, cnt_rem, cnt_abt, err_at, rdy_pct;
  int n_cmp = 0, n_bad = 0;

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(bit cy, bit lk, bit lie, bit rie);
    return {27'd0, rie, lie, 1'b0, lk, cy};
  endfunction

  task automatic put_data(input int a, input bit cy, input bit lie, input bit rie,
                          input logic [31:0] len, input logic [63:0] s, input logic [63:0] d,
                          input bit expect_it);
    int i = a >> 2;
    mem[i] = ctl(cy, 1'b0, lie, rie); mem[i+1] = len;
    mem[i+2] = s[31:0]; mem[i+3] = s[63:32];
    mem[i+4] = d[31:0]; mem[i+5] = d[63:32];
    if (expect_it) begin
      e_src[n_exp] = s; e_dst[n_exp] = d; e_len[n_exp] = len; n_exp++;
    end
  endtask

  task automatic put_link(input int a, input bit cy, input logic [63:0] nxt);
    int i = a >> 2;
    mem[i] = ctl(cy, 1'b1, 1'b0, 1'b0); mem[i+1] = 32'd0;
    mem[i+2] = nxt[31:0]; mem[i+3] = nxt[63:32];
  endtask

  task automatic put_stop(input int a, input bit cy);
    int i = a >> 2;
    mem[i] = ctl(cy, 1'b0, 1'b1, 1'b1); mem[i+1] = 32'd9;
  endtask

  task automatic clear_logs;
    n_exp = 0; n_got = 0; cnt_loc = 0; cnt_rem = 0; cnt_abt = 0; err_at = -1;
  endtask

  task automatic ring(input bit ld, input logic [AW-1:0] a);
    @(negedge clk); db_valid = 1'b1; db_load = ld; db_addr = a;
    @(negedge clk); db_valid = 1'b0; db_load = 1'b0;
  endtask

  task automatic wait_idle;
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_cmds(input string tag);
    chk({tag, " command count"}, 64'(n_got), 64'(n_exp));
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      chk({tag, " src"}, g_src[k], e_src[k]);
      chk({tag, " dst"}, g_dst[k], e_dst[k]);
      chk({tag, " len"}, 64'(g_len[k]), 64'(e_len[k]));
    end
  endtask

  // memory, data mover and interrupt counters, all at the falling edge
  initial begin
    bit m_pend = 1'b0, c_pend = 1'b0, c_err = 1'b0;
    int m_lat = 0, c_lat = 0;
    logic [AW-1:0] m_addr = '0;
    forever begin
      @(negedge clk);
      if (irq_done_loc) cnt_loc++;
      if (irq_done_rem) cnt_rem++;
      if (irq_abort)    cnt_abt++;
      mem_rsp_valid = 1'b0;
      if (m_pend) begin
        if (m_lat == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem[m_addr[11:2]]; m_pend = 1'b0;
        end else m_lat--;
      end
      mem_req_ready = (($urandom % 100) < rdy_pct);
      if (mem_req_valid && mem_req_ready && !m_pend) begin
        m_pend = 1'b1; m_lat = $urandom % 3; m_addr = mem_req_addr;
      end
      cpl_valid = 1'b0; cpl_err = 1'b0;
      if (c_pend) begin
        if (c_lat == 0) begin
          cpl_valid = 1'b1; cpl_err = c_err; c_pend = 1'b0;
        end else c_lat--;
      end
      cmd_ready = (($urandom % 100) < rdy_pct);
      if (cmd_valid && cmd_ready && !c_pend) begin
        g_src[n_got] = cmd_src; g_dst[n_got] = cmd_dst; g_len[n_got] = cmd_len;
        c_err = (n_got == err_at); c_pend = 1'b1; c_lat = $urandom % 4;
        n_got++;
      end
    end
  end

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL R3 watchdog expired act=busy exp=idle");
    finish_run();
  end

  initial begin
    int a, nd, eloc, erem;
    logic [31:0] len;
    bit lie, rie;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    clear_logs();
    rdy_pct = 70;
    repeat (3) @(negedge clk);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 cmd_valid", 64'(cmd_valid), 64'd0);
    chk("R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk("R1 sticky", 64'({st_done, st_abort}), 64'd0);
    chk("R1 pulses", 64'({irq_done_loc, irq_done_rem, irq_abort}), 64'd0);
    chk("R1 cons_cycle", 64'(cons_cycle), 64'd1);
    chk("R11 cmd_dir", 64'(cmd_dir), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 cons_cycle after release", 64'(cons_cycle), 64'd1);

    // two lists joined by a link, ended by a stale descriptor
    clear_logs();
    put_data(32'h000, 1, 0, 0, 32'd64,  64'h1000_0000_0000_0001, 64'h2000_0000_0000_0003, 1);
    put_data(32'h018, 1, 0, 0, 32'd1,   64'h0000_0000_0000_0fff, 64'h0000_0001_0000_0001, 1);
    put_data(32'h030, 1, 1, 0, 32'hffff_ffff, 64'hdead_beef_0000_0005, 64'h0, 1);
    put_link(32'h048, 1, 64'h0000_0000_0000_0200);
    put_data(32'h200, 0, 0, 0, 32'd300, 64'h5, 64'h7, 1);
    put_data(32'h218, 0, 0, 1, 32'd2,   64'h11, 64'h13, 1);
    put_stop(32'h230, 1);
    ring(1'b1, 32'h000);
    wait_idle();
    cmp_cmds("R2 R4");
    chk("R4 cycle flipped by link", 64'(cons_cycle), 64'd0);
    chk("R3 stale descriptor stops walker", 64'(busy), 64'd0);
    chk("R8 local done pulses", 64'(cnt_loc), 64'd1);
    chk("R8 remote done pulses", 64'(cnt_rem), 64'd1);
    chk("R9 sticky done set", 64'(st_done), 64'd1);
    chk("R9 no abort", 64'(st_abort), 64'd0);

    // resume at the held address after software fills the stale slot
    clear_logs();
    put_data(32'h230, 0, 1, 1, 32'd77, 64'h99, 64'h88, 1);
    put_stop(32'h248, 1);
    ring(1'b0, 32'h700);
    wait_idle();
    cmp_cmds("R5 resume");
    chk("R8 both enables local", 64'(cnt_loc), 64'd1);
    chk("R8 both enables remote", 64'(cnt_rem), 64'd1);
    @(negedge clk); clr_done = 1'b1;
    @(negedge clk); clr_done = 1'b0;
    @(negedge clk);
    chk("R9 done cleared", 64'(st_done), 64'd0);

    // zero length descriptor
    clear_logs();
    put_data(32'h300, 1, 1, 0, 32'd0, 64'h1, 64'h2, 0);
    ring(1'b1, 32'h300);
    wait_idle();
    chk("R6 no command", 64'(n_got), 64'd0);
    chk("R6 abort pulse", 64'(cnt_abt), 64'd1);
    chk("R6 err_addr", 64'(err_addr), 64'h300);
    chk("R6 sticky abort", 64'(st_abort), 64'd1);
    chk("R5 load resets cycle", 64'(cons_cycle), 64'd1);
    chk("R6 no done", 64'(cnt_loc), 64'd0);
    @(negedge clk); clr_abort = 1'b1;
    @(negedge clk); clr_abort = 1'b0;
    @(negedge clk);
    chk("R9 abort cleared", 64'(st_abort), 64'd0);

    // failing completion on the second descriptor
    clear_logs();
    err_at = 1;
    put_data(32'h400, 1, 0, 0, 32'd10, 64'h40, 64'h41, 1);
    put_data(32'h418, 1, 1, 0, 32'd20, 64'h42, 64'h43, 1);
    put_data(32'h430, 1, 1, 0, 32'd30, 64'h44, 64'h45, 0);
    put_stop(32'h448, 0);
    ring(1'b1, 32'h400);
    wait_idle();
    cmp_cmds("R7");
    chk("R7 abort pulse", 64'(cnt_abt), 64'd1);
    chk("R7 err_addr", 64'(err_addr), 64'h418);
    chk("R7 no done on failed element", 64'(cnt_loc), 64'd0);
    chk("R7 sticky abort", 64'(st_abort), 64'd1);
    @(negedge clk); clr_abort = 1'b1;
    @(negedge clk); clr_abort = 1'b0;

    // random lists under varied back-pressure
    for (int r = 0; r < 3; r++) begin
      clear_logs();
      rdy_pct = 35 + r * 30;
      a = 32'h500 + r * 32'h100;
      nd = 4 + ($urandom % 5);
      eloc = 0; erem = 0;
      for (int k = 0; k < nd; k++) begin
        lie = (($urandom % 4) == 0);
        rie = (($urandom % 4) == 0);
        len = $urandom;
        if (len == 32'd0) len = 32'd1;
        put_data(a, 1, lie, rie, len, {$urandom, $urandom}, {$urandom, $urandom}, 1);
        eloc += int'(lie); erem += int'(rie);
        a += 24;
      end
      put_stop(a, 0);
      ring(1'b1, 32'h500 + r * 32'h100);
      if (r == 0) begin
        repeat (5) @(negedge clk);
        chk("R5 walker busy at second doorbell", 64'(busy), 64'd1);
        @(negedge clk); db_valid = 1'b1; db_load = 1'b1; db_addr = 32'h000;
        @(negedge clk); db_valid = 1'b0; db_load = 1'b0;
      end
      wait_idle();
      cmp_cmds("R2 R10 random");
      chk("R8 random local count", 64'(cnt_loc), 64'(eloc));
      chk("R8 random remote count", 64'(cnt_rem), 64'(erem));
      chk("R6 random no abort", 64'(cnt_abt), 64'd0);
    end
    finish_run();
  end
endmodule